// File: doc/BRIEF.md
# Splittable Auto-Reload Up-Counter

This block is a 32-bit up-counter made of four 8-bit segments. A split bit at each of the three segment boundaries decides whether the carry out of the lower segment drives the upper segment (joined) or whether the upper segment counts on its own (split). One counter can therefore act as a single 32-bit timer, or as any mix of independent 8-, 16- and 24-bit timers whose boundaries fall on bytes. Every independent timer has its own reload bytes. When it counts past all-ones, the whole group loads those bytes in the same clock edge and raises a one-cycle overflow pulse.

Each segment picks its count qualifier with a two-bit source field. The choices are every module clock, an external tick pulse (for example another timer's overflow or underflow), the cascade input, or nothing. A segment joined to the one below ignores its own source field and counts on the carry. The overflow of the highest segment also drives the cascade output. Feeding that output into a second instance's cascade input, with the source of that instance's base segment set to cascade, builds a 64-bit timer. The upper half then steps one clock after the lower half wraps.

Software writes counter bytes with per-byte enables, and such a write is accepted only while that segment is stopped. Reload bytes can be written at any time. Control (split bits, run bits, source fields) is loaded by a single write strobe. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `split_timer`

## Requirements
- R1: After reset every counter byte, reload byte, split bit, run bit and source field is 0: one joined 32-bit timer, stopped, source every clock. `cnt_o`, `rld_o`, `ovf_o` and `casc_out` read 0 and stay so until written.
- R2: A running segment steps by exactly one per qualifying clock. Source code 2'b00 steps every clock, 2'b01 steps on `ext_tick`, 2'b10 steps on `casc_in` and 2'b11 never steps. The field for segment k sits at `ctrl_src[2k+1:2k]`, and segment k covers `cnt_o[8k+7:8k]`.
- R3: `ctrl_split[i]` = 1 cuts the boundary between segment i and segment i+1 (counter bit 8(i+1)), so segment i+1 counts from its own source. `ctrl_split[i]` = 0 joins them, so segment i+1 steps only when segment i is at 8'hFF and steps.
- R4: A group of joined segments overflows only when every byte in it is 8'hFF and a step occurs. At that edge all of its bytes load their reload bytes together.
- R5: In the cycle after a group's overflow edge, `ovf_o` is 1 at the bit of the group's highest segment for exactly that cycle (again on every further overflow). Bits of segments that are not the top of a group stay 0.
- R6: `casc_out` equals `ovf_o[3]` in every cycle.
- R7: Each segment runs only while its `ctrl_run` bit is 1 and otherwise holds its value. A counter write (`cnt_we[k]`) loads byte k from `cnt_wdata` only while segment k is stopped and is ignored while it runs.
- R8: A reload write (`rld_we[k]`) changes byte k of `rld_o` at once, leaves the running count undisturbed, and is used from the next overflow on.
- R9: `ctrl_we` loads split, run and source at the clock edge. Counting at that same edge still uses the previous control; the new control applies from the next edge.
- R10: Split timers are independent: the overflow or reload of one never changes the bytes of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load control fields |
| ctrl_split | input | 3 | Boundary cut bits, bit i between segments i and i+1 |
| ctrl_run | input | 4 | Run enable per segment |
| ctrl_src | input | 8 | Count source, two bits per segment |
| ext_tick | input | 1 | External count pulse (another timer's overflow/underflow) |
| casc_in | input | 1 | Cascade carry from a lower instance |
| cnt_we | input | 4 | Per-byte counter write enables |
| cnt_wdata | input | 32 | Counter write data |
| rld_we | input | 4 | Per-byte reload write enables |
| rld_wdata | input | 32 | Reload write data |
| cnt_o | output | 32 | Current counter value |
| rld_o | output | 32 | Current reload value |
| ovf_o | output | 4 | Overflow pulse per group top segment |
| casc_out | output | 1 | Cascade carry, the top segment's overflow |

## Verification
All inputs are sampled at a rising edge. Counter, reload and control writes and count steps show on `cnt_o` and `rld_o` right after that edge. The overflow pulse on `ovf_o` and `casc_out` is registered: it is high during the cycle that starts at the overflow edge, which is the cycle where `cnt_o` already shows the reloaded value. A control write governs counting only from the following edge. The bench drives inputs 2 ns after a rising edge. Its behavioural model advances at each rising edge from those inputs, and the full output set is compared at every falling edge, so each result is checked in the cycle in which it is due.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  // count qualifier choice per segment
  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_CASC = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;

  localparam int SRC_W = 2;

endpackage

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl #(
  parameter int NUM_SEG = 4,
  parameter int SRC_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_we,
  input  logic [NUM_SEG-2:0]       split_in,
  input  logic [NUM_SEG-1:0]       run_in,
  input  logic [SRC_W*NUM_SEG-1:0] src_in,
  output logic [NUM_SEG-2:0]       split_q,
  output logic [NUM_SEG-1:0]       run_q,
  output logic [SRC_W*NUM_SEG-1:0] src_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q <= '0;
      run_q   <= '0;
      src_q   <= '0;
    end else if (ctrl_we) begin
      split_q <= split_in;
      run_q   <= run_in;
      src_q   <= src_in;
    end
  end

  // R9
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ($stable(split_q) && $stable(run_q) && $stable(src_q)));

endmodule

// File: rtl/split_timer_src_mux.sv
module split_timer_src_mux
  import split_timer_pkg::*;
#(
  parameter int NUM_SEG = 4
) (
  input  logic [SRC_W*NUM_SEG-1:0] src_q,
  input  logic                     ext_tick,
  input  logic                     casc_in,
  output logic [NUM_SEG-1:0]       tick
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_sel
    src_e sel;
    assign sel = src_e'(src_q[SRC_W*g +: SRC_W]);
    always_comb begin
      case (sel)
        SRC_CLK:  tick[g] = 1'b1;
        SRC_EXT:  tick[g] = ext_tick;
        SRC_CASC: tick[g] = casc_in;
        default:  tick[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/split_timer_chain.sv
module split_timer_chain #(
  parameter int NUM_SEG = 4
) (
  input  logic [NUM_SEG-1:0] run,
  input  logic [NUM_SEG-1:0] tick,
  input  logic [NUM_SEG-1:0] ones,
  input  logic [NUM_SEG-2:0] split,
  output logic [NUM_SEG-1:0] step,
  output logic [NUM_SEG-1:0] ld,
  output logic [NUM_SEG-1:0] ovf_nxt
);

  logic [NUM_SEG-1:0] top_v;
  logic [NUM_SEG-1:0] base_v;

  assign top_v  = {1'b1, split};
  assign base_v = {split, 1'b1};

  always_comb begin
    logic [NUM_SEG-1:0] s;
    logic [NUM_SEG-1:0] w;
    logic [NUM_SEG-1:0] l;
    s[0] = run[0] & tick[0];
    for (int i = 1; i < NUM_SEG; i++) begin
      s[i] = run[i] & (base_v[i] ? tick[i] : (s[i-1] & ones[i-1]));
    end
    w = s & ones;
    l[NUM_SEG-1] = w[NUM_SEG-1];
    for (int i = NUM_SEG - 2; i >= 0; i--) begin
      l[i] = top_v[i] ? w[i] : l[i+1];
    end
    step    = s;
    ld      = l;
    ovf_nxt = w & top_v;
  end

endmodule

// File: rtl/split_timer_seg.sv
module split_timer_seg #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             ld_i,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic             rld_we_i,
  input  logic [SEG_W-1:0] rld_wdata_i,
  output logic [SEG_W-1:0] cnt_o,
  output logic [SEG_W-1:0] rld_o,
  output logic             ones_o
);

  logic [SEG_W-1:0] cnt_q;
  logic [SEG_W-1:0] rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= rld_q;
    end else if (step_i) begin
      cnt_q <= cnt_q + SEG_W'(1);
    end else if (wr_i && !run_i) begin
      cnt_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q <= '0;
    end else if (rld_we_i) begin
      rld_q <= rld_wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign ones_o = &cnt_q;

  // R2
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_i) |=> (cnt_q == $past(cnt_q) + SEG_W'(1)));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(rld_q)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !ld_i && !(wr_i && !run_i)) |=> $stable(cnt_q));

  // R7
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !step_i);

  // R8
  rld_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_we_i |=> $stable(rld_q));

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 4,
  localparam int CNT_W  = SEG_W * NUM_SEG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_we,
  input  logic [NUM_SEG-2:0]       ctrl_split,
  input  logic [NUM_SEG-1:0]       ctrl_run,
  input  logic [SRC_W*NUM_SEG-1:0] ctrl_src,
  input  logic                     ext_tick,
  input  logic                     casc_in,
  input  logic [NUM_SEG-1:0]       cnt_we,
  input  logic [CNT_W-1:0]         cnt_wdata,
  input  logic [NUM_SEG-1:0]       rld_we,
  input  logic [CNT_W-1:0]         rld_wdata,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [CNT_W-1:0]         rld_o,
  output logic [NUM_SEG-1:0]       ovf_o,
  output logic                     casc_out
);

  logic [NUM_SEG-2:0]       split_q;
  logic [NUM_SEG-1:0]       run_q;
  logic [SRC_W*NUM_SEG-1:0] src_q;
  logic [NUM_SEG-1:0]       tick;
  logic [NUM_SEG-1:0]       ones;
  logic [NUM_SEG-1:0]       step;
  logic [NUM_SEG-1:0]       ld;
  logic [NUM_SEG-1:0]       ovf_nxt;
  logic [NUM_SEG-1:0]       ovf_q;
  logic [NUM_SEG-1:0]       top_v;

  split_timer_ctrl #(.NUM_SEG(NUM_SEG), .SRC_W(SRC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .split_in (ctrl_split),
    .run_in   (ctrl_run),
    .src_in   (ctrl_src),
    .split_q  (split_q),
    .run_q    (run_q),
    .src_q    (src_q)
  );

  split_timer_src_mux #(.NUM_SEG(NUM_SEG)) u_src (
    .src_q    (src_q),
    .ext_tick (ext_tick),
    .casc_in  (casc_in),
    .tick     (tick)
  );

  split_timer_chain #(.NUM_SEG(NUM_SEG)) u_chain (
    .run     (run_q),
    .tick    (tick),
    .ones    (ones),
    .split   (split_q),
    .step    (step),
    .ld      (ld),
    .ovf_nxt (ovf_nxt)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    split_timer_seg #(.SEG_W(SEG_W)) u_seg (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step[g]),
      .ld_i        (ld[g]),
      .run_i       (run_q[g]),
      .wr_i        (cnt_we[g]),
      .wdata_i     (cnt_wdata[SEG_W*g +: SEG_W]),
      .rld_we_i    (rld_we[g]),
      .rld_wdata_i (rld_wdata[SEG_W*g +: SEG_W]),
      .cnt_o       (cnt_o[SEG_W*g +: SEG_W]),
      .rld_o       (rld_o[SEG_W*g +: SEG_W]),
      .ones_o      (ones[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else begin
      ovf_q <= ovf_nxt;
    end
  end

  assign ovf_o    = ovf_q;
  assign casc_out = ovf_q[NUM_SEG-1];
  assign top_v    = {1'b1, split_q};

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
    // R5
    ovf_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[g] |-> $past(top_v[g]));

    // R5
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[g] |-> $past(ld[g]));
  end

  for (genvar g = 1; g < NUM_SEG; g++) begin : g_iso
    // R3
    split_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_q[g-1] && !tick[g]) |-> !step[g]);
  end

endmodule

// File: tb/split_timer_bench.sv
module split_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [2:0]  ctrl_split = '0;
  logic [3:0]  ctrl_run = '0;
  logic [7:0]  ctrl_src = '0;
  logic        ext_tick = 1'b0;
  logic        casc_in = 1'b0;
  logic [3:0]  cnt_we = '0;
  logic [31:0] cnt_wdata = '0;
  logic [3:0]  rld_we = '0;
  logic [31:0] rld_wdata = '0;
  logic [31:0] cnt_o;
  logic [31:0] rld_o;
  logic [3:0]  ovf_o;
  logic        casc_out;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  split_timer u_split_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_split(ctrl_split),
    .ctrl_run(ctrl_run), .ctrl_src(ctrl_src), .ext_tick(ext_tick),
    .casc_in(casc_in), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata), .cnt_o(cnt_o), .rld_o(rld_o),
    .ovf_o(ovf_o), .casc_out(casc_out)
  );

  // behavioural reference model
  int       m_cnt [4];
  int       m_rld [4];
  bit [2:0] m_split;
  bit [3:0] m_run;
  bit [1:0] m_src [4];
  bit [3:0] m_ovf;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_cnt[k] = 0; m_rld[k] = 0; m_src[k] = 2'b00;
      end
      m_split = '0; m_run = '0; m_ovf = '0;
    end else begin
      bit [3:0] tk;
      bit [3:0] nov;
      int nc [4];
      int b;
      int t;
      longint unsigned val;
      longint unsigned rv;
      longint unsigned mx;
      for (int k = 0; k < 4; k++) begin
        case (m_src[k])
          2'b00:   tk[k] = 1'b1;
          2'b01:   tk[k] = ext_tick;
          2'b10:   tk[k] = casc_in;
          default: tk[k] = 1'b0;
        endcase
      end
      nc = m_cnt;
      nov = '0;
      b = 0;
      while (b < 4) begin
        t = b;
        while (t < 3 && !m_split[t]) t++;
        val = 0; rv = 0;
        for (int k = b; k <= t; k++) begin
          val |= longint'(m_cnt[k]) << (8 * (k - b));
          rv  |= longint'(m_rld[k]) << (8 * (k - b));
        end
        mx = (64'd1 << (8 * (t - b + 1))) - 1;
        if (m_run[b] && tk[b]) begin
          if (val == mx) begin
            val = rv;
            nov[t] = 1'b1;
          end else begin
            val = val + 1;
          end
          for (int k = b; k <= t; k++) nc[k] = int'((val >> (8 * (k - b))) & 255);
        end
        b = t + 1;
      end
      for (int k = 0; k < 4; k++) begin
        if (cnt_we[k] && !m_run[k]) nc[k] = int'(cnt_wdata[8*k +: 8]);
        if (rld_we[k]) m_rld[k] = int'(rld_wdata[8*k +: 8]);
      end
      m_cnt = nc;
      m_ovf = nov;
      if (ctrl_we) begin
        m_split = ctrl_split;
        m_run = ctrl_run;
        for (int k = 0; k < 4; k++) m_src[k] = ctrl_src[2*k +: 2];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] ec;
      logic [31:0] er;
      for (int k = 0; k < 4; k++) begin
        ec[8*k +: 8] = 8'(m_cnt[k]);
        er[8*k +: 8] = 8'(m_rld[k]);
      end
      chk(cur_req, "cnt_o", cnt_o, ec);
      chk("R8", "rld_o", rld_o, er);
      chk("R5", "ovf_o", {28'd0, ovf_o}, {28'd0, m_ovf});
      chk("R6", "casc_out", {31'd0, casc_out}, {31'd0, m_ovf[3]});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      ctrl_we = 1'b0; cnt_we = '0; rld_we = '0;
    end
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ext_tick = lfsr[0];
      casc_in  = lfsr[3] & lfsr[5];
      cyc(1);
    end
    ext_tick = 1'b0;
    casc_in  = 1'b0;
  endtask

  task automatic set_ctrl(input logic [2:0] sp, input logic [3:0] rn, input logic [7:0] sr);
    ctrl_we = 1'b1; ctrl_split = sp; ctrl_run = rn; ctrl_src = sr;
    cyc(1);
  endtask

  task automatic load(input logic [31:0] c, input logic [31:0] r);
    cnt_we = 4'hF; cnt_wdata = c; rld_we = 4'hF; rld_wdata = r;
    cyc(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, requirement R1..all incomplete actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    bit seen;
    // R1 reset state
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R1", "cnt after reset", cnt_o, 32'h0);
    chk("R1", "rld after reset", rld_o, 32'h0);
    chk("R1", "ovf after reset", {28'd0, ovf_o}, 32'h0);
    cyc(5);
    chk("R1", "stopped after reset", cnt_o, 32'h0);

    // R7 write while stopped
    cur_req = "R7";
    load(32'hFFFF_FFF0, 32'h1234_5678);
    chk("R7", "stopped write", cnt_o, 32'hFFFF_FFF0);

    // R4 joined 32-bit overflow
    cur_req = "R4";
    set_ctrl(3'b000, 4'hF, 8'h00);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      cyc(1);
      if (casc_out) begin
        seen = 1'b1;
        chk("R4", "group reload", cnt_o, 32'h1234_5678);
        chk("R5", "top pulse only", {28'd0, ovf_o}, 32'h8);
      end
    end
    chk("R6", "cascade seen", {31'd0, seen}, 32'h1);

    // R7 write ignored while running
    v = cnt_o;
    cnt_we = 4'hF; cnt_wdata = 32'h0;
    cyc(1);
    chk("R7", "write ignored while running", cnt_o, v + 32'd1);

    // R9 stop takes effect after the write edge
    cur_req = "R9";
    set_ctrl(3'b000, 4'h0, 8'h00);
    v = cnt_o;
    cyc(3);
    chk("R9", "held after stop", cnt_o, v);

    // R3 / R10 four split 8-bit timers with mixed sources
    cur_req = "R3";
    load(32'hFA10_FEF0, 32'h0403_0201);
    set_ctrl(3'b111, 4'hF, {2'b10, 2'b11, 2'b01, 2'b00});
    run_rand(100);
    // R8 reload change while running
    cur_req = "R8";
    rld_we = 4'h1; rld_wdata = 32'h0000_0080;
    v = cnt_o;
    cyc(1);
    chk("R8", "count undisturbed", {24'd0, cnt_o[7:0]},
        (v[7:0] == 8'hFF) ? 32'h01 : {24'd0, v[7:0] + 8'd1});
    seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      cyc(1);
      if (ovf_o[0]) begin
        seen = 1'b1;
        chk("R8", "new reload used", {24'd0, cnt_o[7:0]}, 32'h80);
      end
    end
    cur_req = "R10";
    run_rand(400);
    chk("R2", "source off holds", {24'd0, cnt_o[23:16]}, 32'h10);

    // R3 16+16
    cur_req = "R3";
    set_ctrl(3'b111, 4'h0, 8'h00);
    load(32'hFFF0_FFF8, 32'h00F0_FF00);
    set_ctrl(3'b010, 4'hF, 8'h10);
    run_rand(400);

    // R4 8+24
    cur_req = "R4";
    set_ctrl(3'b010, 4'h0, 8'h00);
    load(32'hFFFF_F000, 32'hABCD_EF12);
    set_ctrl(3'b001, 4'hF, 8'h00);
    cyc(300);

    // R4 24+8
    set_ctrl(3'b001, 4'h0, 8'h00);
    load(32'h80FF_FFE0, 32'h1122_3344);
    set_ctrl(3'b100, 4'hF, 8'h00);
    cyc(300);

    // R5 reload of all-ones overflows every cycle
    cur_req = "R5";
    set_ctrl(3'b100, 4'h0, 8'h00);
    load(32'h0000_00FF, 32'h0000_00FF);
    set_ctrl(3'b111, 4'h1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk("R5", "repeated pulse", {28'd0, ovf_o}, 32'h1);
    end
    set_ctrl(3'b111, 4'h0, 8'h00);
    cyc(3);
    chk("R5", "pulse ends", {28'd0, ovf_o}, 32'h0);

    // R2 cascade-input source on a single segment
    cur_req = "R2";
    load(32'h0000_0000, 32'h0000_0000);
    set_ctrl(3'b111, 4'h1, 8'h02);
    casc_in = 1'b1; cyc(1);
    casc_in = 1'b0; cyc(2);
    chk("R2", "one cascade step", {24'd0, cnt_o[7:0]}, 32'h01);

    finish_run();
  end

endmodule